// File: doc/BRIEF.md
# Packet Event Status and Interrupt Combiner

This block holds the pending-packet state that a transmit DMA engine and a receive DMA engine report. Each engine raises single-cycle pulses: one when a packet completes and one for an error (transmit underrun, receive overflow). Every packet pulse adds one to an 8-bit pending count. Software acknowledges one packet at a time by writing a 1 to bit 0 of the status word. This subtracts one from the count, and the packet flag stays set until the count reaches zero. Error bits are sticky and clear when software writes a 1 to them.

The low nibbles of both status words form an 8-bit raw event vector. A software mask gates this vector, and a single registered level interrupt is raised while any unmasked event remains. A receive overflow also drops the receive DMA enable, which software must set again. Software sees everything through a plain word-addressed register port: write strobe, 3-bit word address, 32-bit write data and combinational read data.

Top module: `pkt_evt_status`

## Requirements
- R1: After reset, all counts, packet flags, error bits, the interrupt mask, the receive enable and `irq_o` are 0.
- R2: A pulse on `tx_sent_i` or `rx_rcvd_i` adds one to that channel's count. The count sits in bits [23:16] of the status word (transmit at word address 0, receive at address 1). Bit 0 of the word reads 1 whenever the count is nonzero.
- R3: A write to a status word with bit 0 set subtracts one from that channel's count. Bit 0 reads 0 only once the count is 0. A write with bit 0 clear leaves the count unchanged.
- R4: When a packet pulse and a bit-0 write hit the same channel in the same cycle, the count is left unchanged.
- R5: The count saturates at 255 on increment and at 0 on decrement.
- R6: `tx_underrun_i` sets transmit bit 1 and `rx_overflow_i` sets receive bit 2. Writing a 1 to that bit clears it. If an error pulse and its clear arrive in the same cycle, the bit stays set.
- R7: The interrupt status (address 3) reads the mask (address 2, bits [7:0]) ANDed with a raw vector. The raw vector holds receive status bits [3:0] in bits [7:4] and transmit status bits [3:0] in bits [3:0].
- R8: `irq_o` is registered: it equals the OR of the interrupt status as it was one clock earlier.
- R9: Writes to the interrupt status address change no state.
- R10: Bit 0 of address 4 is the receive DMA enable and drives `rx_dma_en_o`. A receive overflow clears it, and the overflow wins over a same-cycle write.
- R11: Addresses 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_sent_i | input | 1 | Transmit packet completed pulse |
| tx_underrun_i | input | 1 | Transmit underrun pulse |
| rx_rcvd_i | input | 1 | Receive packet stored pulse |
| rx_overflow_i | input | 1 | Receive overflow pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| rx_dma_en_o | output | 1 | Receive DMA enable |
| irq_o | output | 1 | Level interrupt |

## Verification
The counters are exercised in four ways:
- Bursts of packet pulses followed by single acknowledges separate real per-event counting from a flag that merely latches.
- Acknowledging past zero and pulsing past 255 expose wraparound in either direction.
- Same-cycle pulse and acknowledge pairs show whether the two actions cancel.
- Writes with bit 0 clear show whether only the acknowledge bit decrements.

Mask patterns that open a single transmit bit, a single receive bit, and all bits show whether the two nibbles land in the right halves of the raw vector. Overflow pulses that coincide with an enable write or with an error clear pin down which side takes priority.

// File: rtl/pes_pkg.sv
package pes_pkg;
  localparam int REG_AW     = 3;
  localparam int NCH        = 2;
  localparam int NIB        = 4;
  localparam int RAW_W      = NCH * NIB;
  localparam int CNT_LSB    = 16;
  localparam int DW         = 32;

  typedef enum logic [REG_AW-1:0] {
    RA_TX_STAT  = 3'd0,
    RA_RX_STAT  = 3'd1,
    RA_IRQ_MASK = 3'd2,
    RA_IRQ_STAT = 3'd3,
    RA_RX_CTL   = 3'd4
  } reg_addr_e;

  // sticky error bit position per channel: tx underrun bit 1, rx overflow bit 2
  function automatic int err_pos(int ch);
    return (ch == 0) ? 1 : 2;
  endfunction
endpackage

// File: rtl/evt_chan.sv
module evt_chan #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  input  logic             err_set_i,
  input  logic             err_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      case ({inc_i, dec_i})
        2'b10:   if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        2'b01:   if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= 1'b0;
    else if (err_set_i) err_q <= 1'b1;
    else if (err_clr_i) err_q <= 1'b0;
  end

  assign cnt_o = cnt_q;
  assign err_o = err_q;
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] stat_o,
  output logic         irq_o
);
  logic irq_q;

  assign stat_o = raw_i & mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |stat_o;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/pkt_evt_status.sv
module pkt_evt_status
  import pes_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_sent_i,
  input  logic              tx_underrun_i,
  input  logic              rx_rcvd_i,
  input  logic              rx_overflow_i,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              rx_dma_en_o,
  output logic              irq_o
);
  logic [NCH-1:0]   ev_cnt, ev_err, hit, err;
  logic [CNT_W-1:0] cnt [NCH];
  logic [DW-1:0]    stat_w [NCH];
  logic [RAW_W-1:0] raw, irq_stat, mask_q;
  logic             rx_en_q;
  logic             unused_wdata;

  assign ev_cnt = {rx_rcvd_i, tx_sent_i};
  assign ev_err = {rx_overflow_i, tx_underrun_i};
  assign unused_wdata = ^reg_wdata_i[DW-1:RAW_W];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [REG_AW-1:0] CH_ADDR = (i == 0) ? REG_AW'(RA_TX_STAT) : REG_AW'(RA_RX_STAT);
    localparam int EP = err_pos(i);

    assign hit[i] = reg_wr_i && (reg_addr_i == CH_ADDR);

    evt_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .inc_i     (ev_cnt[i]),
      .dec_i     (hit[i] && reg_wdata_i[0]),
      .err_set_i (ev_err[i]),
      .err_clr_i (hit[i] && reg_wdata_i[EP]),
      .cnt_o     (cnt[i]),
      .err_o     (err[i])
    );

    always_comb begin
      stat_w[i]                  = '0;
      stat_w[i][CNT_LSB +: CNT_W] = cnt[i];
      stat_w[i][0]               = |cnt[i];
      stat_w[i][EP]              = err[i];
    end

    assign raw[i*NIB +: NIB] = stat_w[i][NIB-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      rx_en_q <= 1'b0;
    end else begin
      if (reg_wr_i && reg_addr_i == RA_IRQ_MASK) mask_q <= reg_wdata_i[RAW_W-1:0];
      if (rx_overflow_i)                         rx_en_q <= 1'b0;
      else if (reg_wr_i && reg_addr_i == RA_RX_CTL) rx_en_q <= reg_wdata_i[0];
    end
  end

  irq_merge #(.W(RAW_W)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (raw),
    .mask_i (mask_q),
    .stat_o (irq_stat),
    .irq_o  (irq_o)
  );

  always_comb begin
    case (reg_addr_i)
      RA_TX_STAT:  reg_rdata_o = stat_w[0];
      RA_RX_STAT:  reg_rdata_o = stat_w[1];
      RA_IRQ_MASK: reg_rdata_o = {{(DW-RAW_W){1'b0}}, mask_q};
      RA_IRQ_STAT: reg_rdata_o = {{(DW-RAW_W){1'b0}}, irq_stat};
      RA_RX_CTL:   reg_rdata_o = {{(DW-1){1'b0}}, rx_en_q};
      default:     reg_rdata_o = '0;
    endcase
  end

  assign rx_dma_en_o = rx_en_q;
endmodule

// File: rtl/pes_checker.sv
module pes_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_sent_i,
  input logic             tx_underrun_i,
  input logic             rx_overflow_i,
  input logic             reg_wr_i,
  input logic [2:0]       reg_addr_i,
  input logic [31:0]      reg_wdata_i,
  input logic             rx_dma_en_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] tx_cnt,
  input logic [CNT_W-1:0] rx_cnt,
  input logic             tx_err,
  input logic             rx_err,
  input logic [7:0]       mask
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic       tx_dec;
  logic [7:0] raw_c;
  assign tx_dec = reg_wr_i && reg_addr_i == 3'd0 && reg_wdata_i[0];
  assign raw_c  = {1'b0, rx_err, 1'b0, |rx_cnt, 2'b00, tx_err, |tx_cnt};

  a_r2_tx_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_sent_i && !tx_dec && tx_cnt != CMAX |=> tx_cnt == $past(tx_cnt) + 1'b1);
  a_r3_tx_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_dec && !tx_sent_i && tx_cnt != '0 |=> tx_cnt == $past(tx_cnt) - 1'b1);
  a_r4_cancel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_sent_i && tx_dec |=> $stable(tx_cnt));
  a_r5_sat_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt == '0 && !tx_sent_i |=> tx_cnt == '0);
  a_r6_err_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_underrun_i |=> tx_err);
  a_r8_irq_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past(|(mask & raw_c)));
  a_r10_ovf_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_overflow_i |=> !rx_dma_en_o && rx_err);
endmodule

bind pkt_evt_status pes_checker #(.CNT_W(CNT_W)) u_pes_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tx_sent_i     (tx_sent_i),
  .tx_underrun_i (tx_underrun_i),
  .rx_overflow_i (rx_overflow_i),
  .reg_wr_i      (reg_wr_i),
  .reg_addr_i    (reg_addr_i),
  .reg_wdata_i   (reg_wdata_i),
  .rx_dma_en_o   (rx_dma_en_o),
  .irq_o         (irq_o),
  .tx_cnt        (cnt[0]),
  .rx_cnt        (cnt[1]),
  .tx_err        (err[0]),
  .rx_err        (err[1]),
  .mask          (mask_q)
);

// File: tb/pkt_evt_status_test.sv
module pkt_evt_status_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ts = 1'b0, tu = 1'b0, rr = 1'b0, ro = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  a = 3'd0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic        rx_en, irq;

  int    checks = 0, failures = 0, cycles = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  pkt_evt_status uut (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_sent_i(ts), .tx_underrun_i(tu), .rx_rcvd_i(rr), .rx_overflow_i(ro),
    .reg_wr_i(wr), .reg_addr_i(a), .reg_wdata_i(wd),
    .reg_rdata_o(rdata), .rx_dma_en_o(rx_en), .irq_o(irq)
  );

  // behavioural reference
  logic [7:0] m_cnt [2];
  logic       m_err [2];
  logic [7:0] m_mask;
  logic       m_rxen, m_irq;

  function automatic logic [7:0] raw_now();
    return {1'b0, m_err[1], 1'b0, m_cnt[1] != 8'd0, 2'b00, m_err[0], m_cnt[0] != 8'd0};
  endfunction

  function automatic logic [31:0] exp_rd(logic [2:0] ad);
    case (ad)
      3'd0: return {8'd0, m_cnt[0], 13'd0, 1'b0, m_err[0], m_cnt[0] != 8'd0};
      3'd1: return {8'd0, m_cnt[1], 13'd0, m_err[1], 1'b0, m_cnt[1] != 8'd0};
      3'd2: return {24'd0, m_mask};
      3'd3: return {24'd0, m_mask & raw_now()};
      3'd4: return {31'd0, m_rxen};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt[0] <= 8'd0; m_cnt[1] <= 8'd0;
      m_err[0] <= 1'b0; m_err[1] <= 1'b0;
      m_mask <= 8'd0; m_rxen <= 1'b0; m_irq <= 1'b0;
    end else begin
      m_irq <= |(m_mask & raw_now());
      for (int ch = 0; ch < 2; ch++) begin
        logic inc, dec, setb, clr;
        inc  = (ch == 0) ? ts : rr;
        setb = (ch == 0) ? tu : ro;
        dec  = wr && a == 3'(ch) && wd[0];
        clr  = wr && a == 3'(ch) && wd[(ch == 0) ? 1 : 2];
        if (inc && !dec && m_cnt[ch] != 8'd255) m_cnt[ch] <= m_cnt[ch] + 8'd1;
        if (dec && !inc && m_cnt[ch] != 8'd0)   m_cnt[ch] <= m_cnt[ch] - 8'd1;
        if (setb)     m_err[ch] <= 1'b1;
        else if (clr) m_err[ch] <= 1'b0;
      end
      if (wr && a == 3'd2) m_mask <= wd[7:0];
      if (ro) m_rxen <= 1'b0;
      else if (wr && a == 3'd4) m_rxen <= wd[0];
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks += 3;
      if (rdata !== exp_rd(a)) begin
        failures++;
        $display("FAIL %s addr=%0d rdata=%h expected=%h", cur_req, a, rdata, exp_rd(a));
      end
      if (irq !== m_irq) begin
        failures++;
        $display("FAIL R8 irq_o=%b expected=%b", irq, m_irq);
      end
      if (rx_en !== m_rxen) begin
        failures++;
        $display("FAIL R10 rx_dma_en_o=%b expected=%b", rx_en, m_rxen);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic drv(input logic t_s, t_u, r_r, r_o, w, input logic [2:0] ad, input logic [31:0] d);
    @(posedge clk); #2;
    ts = t_s; tu = t_u; rr = r_r; ro = r_o; wr = w; a = ad; wd = d;
  endtask

  task automatic idle(input logic [2:0] ad, input int n);
    for (int k = 0; k < n; k++) drv(0, 0, 0, 0, 0, ad, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rdata !== 32'd0 || irq !== 1'b0 || rx_en !== 1'b0) begin
      failures++;
      $display("FAIL R1 rdata=%h irq=%b rx_en=%b expected=0/0/0", rdata, irq, rx_en);
    end

    cur_req = "R2";
    for (int k = 0; k < 3; k++) drv(1, 0, 0, 0, 0, 3'd0, 0);
    idle(3'd0, 2);
    for (int k = 0; k < 2; k++) drv(0, 0, 1, 0, 0, 3'd1, 0);
    idle(3'd1, 2);

    cur_req = "R3";
    drv(0, 0, 0, 0, 1, 3'd0, 32'hFFFF_FFFE);
    idle(3'd0, 1);
    for (int k = 0; k < 2; k++) drv(0, 0, 0, 0, 1, 3'd0, 32'd1);
    idle(3'd0, 2);

    cur_req = "R5";
    drv(0, 0, 0, 0, 1, 3'd0, 32'd1);
    drv(0, 0, 0, 0, 1, 3'd0, 32'd1);
    idle(3'd0, 1);
    for (int k = 0; k < 260; k++) drv(0, 0, 1, 0, 0, 3'd1, 0);
    idle(3'd1, 1);
    drv(0, 0, 0, 0, 1, 3'd1, 32'd1);
    idle(3'd1, 1);

    cur_req = "R4";
    drv(1, 0, 0, 0, 0, 3'd0, 0);
    drv(1, 0, 0, 0, 1, 3'd0, 32'd1);
    drv(0, 0, 1, 0, 1, 3'd1, 32'd1);
    idle(3'd0, 2);

    cur_req = "R6";
    drv(0, 1, 0, 0, 0, 3'd0, 0);
    idle(3'd0, 1);
    drv(0, 1, 0, 0, 1, 3'd0, 32'd2);
    idle(3'd0, 1);
    drv(0, 0, 0, 0, 1, 3'd0, 32'd2);
    idle(3'd0, 1);
    drv(0, 0, 0, 1, 0, 3'd1, 0);
    idle(3'd1, 1);
    drv(0, 0, 0, 0, 1, 3'd1, 32'd4);
    idle(3'd1, 1);

    cur_req = "R7";
    drv(0, 1, 0, 1, 0, 3'd3, 0);
    drv(0, 0, 0, 0, 1, 3'd2, 32'h0000_0001);
    idle(3'd3, 2);
    drv(0, 0, 0, 0, 1, 3'd2, 32'h0000_0010);
    idle(3'd3, 2);
    drv(0, 0, 0, 0, 1, 3'd2, 32'h0000_0004);
    idle(3'd3, 2);
    drv(0, 0, 0, 0, 1, 3'd2, 32'h0000_00FF);
    idle(3'd3, 2);

    cur_req = "R8";
    drv(0, 0, 0, 0, 1, 3'd0, 32'h2);
    drv(0, 0, 0, 0, 1, 3'd1, 32'h4);
    idle(3'd3, 2);
    drv(0, 0, 0, 0, 1, 3'd2, 32'd0);
    idle(3'd3, 2);

    cur_req = "R9";
    drv(0, 0, 0, 0, 1, 3'd3, 32'hFFFF_FFFF);
    idle(3'd2, 1);
    idle(3'd0, 1);
    idle(3'd1, 1);

    cur_req = "R10";
    drv(0, 0, 0, 0, 1, 3'd4, 32'd1);
    idle(3'd4, 2);
    drv(0, 0, 0, 1, 0, 3'd4, 0);
    idle(3'd4, 1);
    drv(0, 0, 0, 0, 1, 3'd4, 32'd1);
    drv(0, 0, 0, 1, 1, 3'd4, 32'd1);
    idle(3'd4, 2);

    cur_req = "R11";
    for (int k = 5; k < 8; k++) drv(0, 0, 0, 0, 1, 3'(k), 32'hFFFF_FFFF);
    for (int k = 5; k < 8; k++) idle(3'(k), 1);
    idle(3'd0, 1);

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule